// File: doc/BRIEF.md
# Event State Buffer Page Handler

This block is the memory-mapped front end for a set of per-queue event state buffers. Each queue holds two independent 2-bit P/Q state fields. One field gates notifications and the other gates escalations. The address space gives every queue a pair of pages of size 2^PAGE_SHIFT bytes. The even page of the pair reaches the notification field and the odd page reaches the escalation field. Both pages carry the same set of operations.

On every accepted request the block does four things:
- It decodes the queue, the field and the operation from the address.
- It reads the selected state and computes the new state together with a load result.
- It writes the new state back in the same cycle.
- It registers the response.

Loads return a value one cycle later. Some stores produce a one-cycle notify pulse that carries the queue and the field; another block routes that pulse. Only 8-byte accesses to enabled queues are honoured. Any other load reads all ones, and any other store is dropped.

Top module: `esb_mmio_page_handler`

## Requirements
- R1: The queue index is `req_addr >> (PAGE_SHIFT+1)`. Address bit PAGE_SHIFT selects the field: 0 selects the notification field and 1 selects the escalation field. An operation on one field never changes any other field or any other queue. PAGE_SHIFT is 12 or 16.
- R2: After reset every field holds 01 (P=0, Q=1). `rsp_valid_o` and `notify_o` are low.
- R3: A load raises `rsp_valid_o` for one cycle, in the cycle after the request. When the load is valid, the result sits in `rsp_data_o[1:0]` with P in bit 1 and Q in bit 0, and all upper bits are zero. A store never raises `rsp_valid_o`.
- R4: A store at offset 0x000–0x3FF is a trigger. The state moves 00→10 and pulses notify. It moves 10→11 and 11→11 without notify. State 01 is left unchanged and gives no notify.
- R5: A load at offset 0x000–0x7FF is an EOI. It returns 1 if Q was set and 0 otherwise. The new state is 10 if Q was set and 00 otherwise.
- R6: A store at offset 0x400–0x7FF is an EOI with the same state change as R5. It pulses notify if Q was set.
- R7: A load at offset 0x800–0xBFF returns the current state and leaves it unchanged.
- R8: A load at offset 0xC00–0xFFF writes offset bits [9:8] as the new state ({P,Q}) and returns the old state.
- R9: A store at offset 0x800–0xBFF on a notification page pulses notify and leaves the state unchanged. The same store on an escalation page does nothing.
- R10: An access is invalid if `req_size` is not 3 (8 bytes), if the queue index is NUM_QUEUES or more, or if its `q_valid_i` bit is clear. An invalid load returns all ones. An invalid store changes no state and gives no notify. A store at offset 0xC00–0xFFF is also ignored.
- R11: `notify_o` is a one-cycle pulse in the cycle after the causing store. During that pulse, `notify_queue_o` carries the queue index and `notify_esc_o` carries the field (1 for escalation). Loads never notify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access request strobe, one access per cycle |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Byte address within the region |
| req_size_i | input | 2 | log2 of the access size in bytes; only 3 is valid |
| q_valid_i | input | NUM_QUEUES | Per-queue enable |
| rsp_valid_o | output | 1 | Load response strobe |
| rsp_data_o | output | DATA_W | Load result |
| notify_o | output | 1 | Notify pulse |
| notify_queue_o | output | QSEL_W | Queue that caused the notify |
| notify_esc_o | output | 1 | Field that caused the notify (1 = escalation) |

## Verification
A corrupted state field does not appear at the ports until that queue and field are touched again. It then shows up at the first get or set load, as a wrong `rsp_data_o` value one cycle after the request. It can also show up earlier, as a notify pulse that is missing or spurious after a trigger or EOI store. The bench therefore keeps a model of every field and follows random stores with loads to the same fields. A steering fault that writes the wrong queue or the wrong page is caught when a later get reads the untouched neighbour.

// File: rtl/esb_pkg.sv
package esb_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_TRIG,
    OP_EOI_LD,
    OP_EOI_ST,
    OP_GET,
    OP_SET,
    OP_INJECT
  } esb_op_e;

  typedef struct packed {
    esb_op_e    op;
    logic       ok;
    logic       esc;
    logic [1:0] set_val;
  } esb_cmd_t;

  localparam logic [1:0] PQ_RESET = 2'b01;
  localparam logic [1:0] SIZE_8B  = 2'd3;

endpackage

// File: rtl/esb_addr_decode.sv
module esb_addr_decode
  import esb_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_QUEUES = 32,
  parameter int QSEL_W     = 5
) (
  input  logic                  req_valid_i,
  input  logic                  req_write_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [1:0]            req_size_i,
  input  logic [NUM_QUEUES-1:0] q_valid_i,
  output esb_cmd_t              cmd_o,
  output logic [QSEL_W-1:0]     qsel_o
);
  localparam int QIDX_W = ADDR_W - PAGE_SHIFT - 1;

  logic [QIDX_W-1:0] idx_full;
  logic [11:0]       off;
  logic              in_range;
  logic              q_en;
  logic [QSEL_W-1:0] qsel;

  assign idx_full = req_addr_i[ADDR_W-1:PAGE_SHIFT+1];
  assign off      = req_addr_i[11:0];
  assign in_range = ({1'b0, idx_full} < (QIDX_W+1)'(NUM_QUEUES));
  assign qsel     = in_range ? idx_full[QSEL_W-1:0] : '0;
  assign q_en     = in_range && q_valid_i[qsel];
  assign qsel_o   = qsel;

  always_comb begin
    cmd_o.ok      = req_valid_i && (req_size_i == SIZE_8B) && q_en;
    cmd_o.esc     = req_addr_i[PAGE_SHIFT];
    cmd_o.set_val = off[9:8];
    cmd_o.op      = OP_NONE;
    if (cmd_o.ok) begin
      if (req_write_i) begin
        unique case (off[11:10])
          2'b00:   cmd_o.op = OP_TRIG;
          2'b01:   cmd_o.op = OP_EOI_ST;
          2'b10:   cmd_o.op = cmd_o.esc ? OP_NONE : OP_INJECT;
          default: cmd_o.op = OP_NONE;
        endcase
      end else begin
        if (!off[11])       cmd_o.op = OP_EOI_LD;
        else if (!off[10])  cmd_o.op = OP_GET;
        else                cmd_o.op = OP_SET;
      end
    end
  end

endmodule

// File: rtl/esb_pq_alu.sv
module esb_pq_alu
  import esb_pkg::*;
(
  input  esb_op_e    op_i,
  input  logic [1:0] set_val_i,
  input  logic [1:0] pq_old_i,
  output logic [1:0] pq_new_o,
  output logic       wr_en_o,
  output logic [1:0] ret_o,
  output logic       notify_o
);
  always_comb begin
    pq_new_o = pq_old_i;
    ret_o    = 2'b00;
    notify_o = 1'b0;
    unique case (op_i)
      OP_TRIG: begin
        unique case (pq_old_i)
          2'b00: begin
            pq_new_o = 2'b10;
            notify_o = 1'b1;
          end
          2'b10, 2'b11: pq_new_o = 2'b11;
          default:      pq_new_o = pq_old_i;
        endcase
      end
      OP_EOI_LD, OP_EOI_ST: begin
        pq_new_o = pq_old_i[0] ? 2'b10 : 2'b00;
        ret_o    = {1'b0, pq_old_i[0]};
        notify_o = (op_i == OP_EOI_ST) && pq_old_i[0];
      end
      OP_GET: ret_o = pq_old_i;
      OP_SET: begin
        pq_new_o = set_val_i;
        ret_o    = pq_old_i;
      end
      OP_INJECT: notify_o = 1'b1;
      default: begin
        pq_new_o = pq_old_i;
      end
    endcase
    wr_en_o = (op_i != OP_NONE) && (pq_new_o != pq_old_i);
  end

endmodule

// File: rtl/esb_state_array.sv
module esb_state_array
  import esb_pkg::*;
#(
  parameter int NUM_QUEUES = 32,
  parameter int QSEL_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [QSEL_W-1:0] wr_q_i,
  input  logic              wr_esc_i,
  input  logic [1:0]        wr_pq_i,
  input  logic [QSEL_W-1:0] rd_q_i,
  input  logic              rd_esc_i,
  output logic [1:0]        rd_pq_o
);
  localparam int NFIELDS = NUM_QUEUES * 2;

  logic [2*NFIELDS-1:0] flat;

  for (genvar gq = 0; gq < NUM_QUEUES; gq++) begin : g_queue
    for (genvar gf = 0; gf < 2; gf++) begin : g_field
      logic       en;
      logic [1:0] pq_q;
      assign en = wr_en_i && (wr_q_i == QSEL_W'(gq)) && (wr_esc_i == gf[0]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  pq_q <= PQ_RESET;
        else if (en) pq_q <= wr_pq_i;
      end
      assign flat[(gq*2+gf)*2 +: 2] = pq_q;
    end
  end

  assign rd_pq_o = flat[(int'(rd_q_i)*2 + int'(rd_esc_i))*2 +: 2];

endmodule

// File: rtl/esb_mmio_page_handler.sv
module esb_mmio_page_handler
  import esb_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_QUEUES = 32,
  parameter int QSEL_W     = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid_i,
  input  logic                  req_write_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [1:0]            req_size_i,
  input  logic [NUM_QUEUES-1:0] q_valid_i,
  output logic                  rsp_valid_o,
  output logic [DATA_W-1:0]     rsp_data_o,
  output logic                  notify_o,
  output logic [QSEL_W-1:0]     notify_queue_o,
  output logic                  notify_esc_o
);
  if (PAGE_SHIFT != 12 && PAGE_SHIFT != 16) begin : g_bad_shift
    $error("PAGE_SHIFT must be 12 or 16");
  end

  esb_cmd_t          cmd;
  logic [QSEL_W-1:0] qsel;
  logic [1:0]        pq_old, pq_new, ret;
  logic              st_wr, alu_notify;

  esb_addr_decode #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
    .NUM_QUEUES(NUM_QUEUES), .QSEL_W(QSEL_W)
  ) u_decode (
    .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_size_i(req_size_i),
    .q_valid_i(q_valid_i), .cmd_o(cmd), .qsel_o(qsel)
  );

  esb_state_array #(.NUM_QUEUES(NUM_QUEUES), .QSEL_W(QSEL_W)) u_state (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(st_wr), .wr_q_i(qsel), .wr_esc_i(cmd.esc), .wr_pq_i(pq_new),
    .rd_q_i(qsel), .rd_esc_i(cmd.esc), .rd_pq_o(pq_old)
  );

  esb_pq_alu u_alu (
    .op_i(cmd.op), .set_val_i(cmd.set_val), .pq_old_i(pq_old),
    .pq_new_o(pq_new), .wr_en_o(st_wr), .ret_o(ret), .notify_o(alu_notify)
  );

  // next-state of the response registers
  logic              rsp_valid_d, notify_d, notify_esc_d;
  logic [DATA_W-1:0] rsp_data_d;
  logic [QSEL_W-1:0] notify_queue_d;
  logic              out_en;

  always_comb begin
    rsp_valid_d    = req_valid_i && !req_write_i;
    rsp_data_d     = '0;
    if (rsp_valid_d) rsp_data_d = cmd.ok ? {{(DATA_W-2){1'b0}}, ret} : '1;
    notify_d       = cmd.ok && alu_notify;
    notify_queue_d = notify_d ? qsel : '0;
    notify_esc_d   = notify_d && cmd.esc;
    out_en         = req_valid_i || rsp_valid_o || notify_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o    <= 1'b0;
      rsp_data_o     <= '0;
      notify_o       <= 1'b0;
      notify_queue_o <= '0;
      notify_esc_o   <= 1'b0;
    end else if (out_en) begin
      rsp_valid_o    <= rsp_valid_d;
      rsp_data_o     <= rsp_data_d;
      notify_o       <= notify_d;
      notify_queue_o <= notify_queue_d;
      notify_esc_o   <= notify_esc_d;
    end
  end

endmodule

// File: rtl/esb_mmio_checker.sv
module esb_mmio_checker #(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int QSEL_W     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [1:0]        req_size_i,
  input logic              rsp_valid_o,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              notify_o,
  input logic [QSEL_W-1:0] notify_queue_o,
  input logic              notify_esc_o
);
  AST_LOAD_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && !req_write_i |=> rsp_valid_o); // R3
  AST_STORE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && req_write_i |=> !rsp_valid_o); // R3
  AST_RSP_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && (rsp_data_o != '1) |-> rsp_data_o[DATA_W-1:2] == '0); // R3
  AST_BAD_SIZE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && !req_write_i && (req_size_i != 2'd3) |=> rsp_data_o == '1); // R10
  AST_INJECT_ESC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && req_write_i && req_addr_i[PAGE_SHIFT] && (req_addr_i[11:10] == 2'b10)
    |=> !notify_o); // R9
  AST_LOAD_NO_NOTIFY: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid_i && req_write_i) |=> !notify_o); // R11
  AST_NOTIFY_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && req_write_i |=> !notify_o || (notify_esc_o == $past(req_addr_i[PAGE_SHIFT]))); // R11
  AST_NOTIFY_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && req_write_i
    |=> !notify_o || (notify_queue_o == $past(req_addr_i[PAGE_SHIFT+1 +: QSEL_W]))); // R1
endmodule

bind esb_mmio_page_handler esb_mmio_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT), .QSEL_W(QSEL_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
  .req_addr_i(req_addr_i), .req_size_i(req_size_i), .rsp_valid_o(rsp_valid_o),
  .rsp_data_o(rsp_data_o), .notify_o(notify_o), .notify_queue_o(notify_queue_o),
  .notify_esc_o(notify_esc_o)
);

// File: tb/esb_mmio_page_handler_tb_top.sv
`timescale 1ns/100ps
module esb_mmio_page_handler_tb_top;
  localparam int AW = 20, DW = 64, PS = 12, NQ = 32, QW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic [NQ-1:0] qv;
  logic          rsp_valid_o, notify_o, notify_esc_o;
  logic [DW-1:0] rsp_data_o;
  logic [QW-1:0] notify_queue_o;

  int  vectors = 0, fails = 0;
  bit  done = 0;
  logic [1:0] ref_pq [NQ][2];

  always #2.5 clk = ~clk;

  esb_mmio_page_handler #(.ADDR_W(AW), .DATA_W(DW), .PAGE_SHIFT(PS), .NUM_QUEUES(NQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .q_valid_i(qv),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o), .notify_o(notify_o),
    .notify_queue_o(notify_queue_o), .notify_esc_o(notify_esc_o));

  task automatic access(input bit wr, input int q, input bit esc,
                        input logic [11:0] off, input logic [1:0] sz);
    bit ok, exp_ntf;
    logic [1:0] old, nw;
    logic [DW-1:0] exp_d;
    string tag;
    ok = (sz == 2'd3) && (q < NQ) && qv[q];
    exp_ntf = 0; exp_d = '0; tag = "R10";
    if (!ok) begin
      if (!wr) exp_d = '1;
    end else begin
      old = ref_pq[q][esc]; nw = old;
      if (wr) begin
        case (off[11:10])
          2'b00: begin tag = "R4";
            if (old == 2'b00) begin nw = 2'b10; exp_ntf = 1; end
            else if (old[1]) nw = 2'b11;
          end
          2'b01: begin tag = "R6"; nw = old[0] ? 2'b10 : 2'b00; exp_ntf = old[0]; end
          2'b10: begin tag = "R9"; exp_ntf = !esc; end
          default: tag = "R10";
        endcase
      end else if (!off[11]) begin
        tag = "R5"; exp_d = {62'd0, 1'b0, old[0]}; nw = old[0] ? 2'b10 : 2'b00;
      end else if (!off[10]) begin
        tag = "R7"; exp_d = {62'd0, old};
      end else begin
        tag = "R8"; exp_d = {62'd0, old}; nw = off[9:8];
      end
      ref_pq[q][esc] = nw;
    end
    req_valid = 1; req_write = wr; req_size = sz;
    req_addr = (AW'(q) << (PS+1)) | (AW'(esc) << PS) | AW'(off);
    @(negedge clk);
    req_valid = 0;
    vectors++;
    if (rsp_valid_o !== !wr || (!wr && rsp_data_o !== exp_d) || notify_o !== exp_ntf ||
        (exp_ntf && (notify_queue_o !== QW'(q) || notify_esc_o !== esc))) begin
      fails++;
      $display("FAIL %s R3 R11 q=%0d esc=%0d off=%h: rv=%b data=%h ntf=%b nq=%0d ne=%b exp rv=%b data=%h ntf=%b",
               tag, q, esc, off, rsp_valid_o, rsp_data_o, notify_o, notify_queue_o,
               notify_esc_o, !wr, exp_d, exp_ntf);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NQ; i++) begin ref_pq[i][0] = 2'b01; ref_pq[i][1] = 2'b01; end
    qv = '1; qv[5] = 1'b0; qv[17] = 1'b0;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_size = 2'd3;
    repeat (3) @(negedge clk);
    vectors++;
    if (rsp_valid_o !== 1'b0 || notify_o !== 1'b0) begin // R2
      fails++; $display("FAIL R2 reset outputs rv=%b ntf=%b exp 0 0", rsp_valid_o, notify_o);
    end
    rst_n = 1;
    @(negedge clk);
    // R2: fields come up as 01
    access(0, 0, 0, 12'h800, 3); access(0, 31, 1, 12'h800, 3);
    // R8 then R4 sequence on queue 0 notification field
    access(0, 0, 0, 12'hC00, 3);   // set 00, old 01
    access(1, 0, 0, 12'h000, 3);   // R4 00->10 notify
    access(1, 0, 0, 12'h3F8, 3);   // R4 10->11 quiet
    access(1, 0, 0, 12'h100, 3);   // R4 11->11 quiet
    access(0, 0, 0, 12'h800, 3);   // R7 get 11
    access(1, 0, 0, 12'h400, 3);   // R6 EOI store, Q set -> notify, 10
    access(0, 0, 0, 12'h000, 3);   // R5 EOI load, Q clear -> 0, 00
    access(0, 0, 0, 12'hF00, 3);   // R8 set 11
    access(0, 0, 0, 12'h7F8, 3);   // R5 returns 1 -> 10
    access(1, 0, 0, 12'h800, 3);   // R9 inject notify
    access(0, 0, 0, 12'h800, 3);   // R9 state unchanged
    access(1, 0, 1, 12'h800, 3);   // R9 escalation inject rejected
    access(0, 0, 1, 12'h800, 3);   // R1 escalation field untouched
    access(0, 1, 0, 12'h800, 3);   // R1 neighbour queue untouched
    access(1, 3, 0, 12'h000, 3);   // R4 01 stays, no notify
    access(0, 3, 0, 12'h800, 3);
    access(0, 0, 0, 12'h800, 2);   // R10 bad size
    access(1, 0, 0, 12'h000, 2);   // R10 bad size store ignored
    access(0, 5, 0, 12'h800, 3);   // R10 disabled queue
    access(1, 5, 0, 12'hD00, 3);
    access(0, 35, 0, 12'h800, 3);  // R10 out of range
    access(1, 2, 1, 12'hC00, 3);   // R10 undecoded store
    access(0, 2, 1, 12'h800, 3);
    access(0, 0, 0, 12'h800, 3);
    // escalation page notify carries field (R11)
    access(0, 9, 1, 12'hC00, 3); access(1, 9, 1, 12'h000, 3);
    for (int i = 0; i < 3000; i++) begin
      bit wr = $urandom_range(0, 1);
      int q  = $urandom_range(0, 39);
      bit e  = $urandom_range(0, 1);
      logic [11:0] off = 12'($urandom_range(0, 4095)) & 12'hFF8;
      logic [1:0]  sz  = ($urandom_range(0, 9) == 0) ? 2'd2 : 2'd3;
      access(wr, q, e, off, sz);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule